// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol side of a byte-addressed serial memory that answers on a two-wire bus. A fast system clock oversamples the already-filtered clock and data lines. A small front end finds clock edges and the bus framing events (start and stop). The engine then follows the bus: it takes a device-address byte, answers only when that byte carries the fixed device code and the three strap bits, and either collects a two-byte word address with write bytes or sends memory bytes back. It drives the data line only through an active-low output enable, so it never drives a one.

Written bytes go out to a separate page-write unit, one at a time with their addresses, followed by a commit pulse when the master closes the transfer. The page-write unit reports its internal write time on a busy input, and the engine does not answer its own address while busy is high, which lets a master poll for completion. Reads go to a synchronous memory port with one cycle of latency. The engine keeps a current-address counter that supports current-address reads, random reads (an address-only write followed by a repeated start) and sequential reads.

Top module: `serial_mem_slave`

## Requirements
- R1: A start condition (data falling while clock is high) at any point aborts the transfer in progress and begins a new device-address byte. A stop condition (data rising while clock is high) ends any transfer and releases the data line. Neither event changes the current-address counter. After reset the data line is released and no write, commit or read request is active.
- R2: The device-address byte arrives MSB first: bits 7..4 are the device code 4'b1010, bits 3..1 must equal strap_sel[2:0], and bit 0 is the direction (1 = read, 0 = write). The engine pulls the data line low during the 9th clock only when code and straps both match. On a mismatch it leaves the line released and ignores the bus until the next start.
- R3: While wr_busy is high at the moment the acknowledge is decided, the engine does not acknowledge its device address. Once wr_busy is low, the same byte is acknowledged again.
- R4: In a write transfer, the two bytes after the device address are the word address, high byte first. Each is acknowledged. Only bits 13:0 select a byte, so the top two bits of the high byte are ignored.
- R5: Each following write byte is acknowledged and handed out as a one-cycle wr_push with wr_addr and wr_data. The address then advances within its 64-byte page: bits 5:0 wrap and bits 13:6 are kept.
- R6: A stop after at least one write byte produces a single one-cycle wr_commit. A transfer that carries only the word address produces none.
- R7: A random read (word address written, then a repeated start with direction 1) returns the byte stored at that address.
- R8: In a read, a master acknowledge (data low on the 9th clock) makes the engine send the byte at the next address. The address wraps from 0x3FFF to 0x0000.
- R9: A read with no word address starts at the current-address counter. The counter is 0 after reset and always holds the last accessed address plus one.
- R10: After a master no-acknowledge, the engine drives nothing until the next start, whatever clocks follow.
- R11: A start, nine clocks with the data line released, and another start bring the engine back to a state where it answers a fresh transfer normally, even when the sequence begins in the middle of a read byte.
- R12: The output enable changes only after a falling clock edge or a start or stop, so read bits and acknowledges stay stable while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Filtered bus clock level |
| sda_in | input | 1 | Filtered bus data level |
| strap_sel | input | 3 | Strap bits the device address must match |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| wr_busy | input | 1 | Page-write unit is in its internal write time |
| wr_push | output | 1 | One-cycle strobe carrying a received write byte |
| wr_addr | output | ADDR_W | Array address of the pushed byte |
| wr_data | output | 8 | Pushed write byte |
| wr_commit | output | 1 | One-cycle strobe: stop closed a transfer that carried data |
| rd_en | output | 1 | Read request to the synchronous memory port |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | 8 | Read data, valid the cycle after rd_en |

## Verification
The hardest case to reach from the ports is the software-reset recovery in the middle of a read byte. There the engine may be driving a zero, so the master's first start attempt may or may not be seen, and either path has to end in idle. The stimulus starts a current-address read, takes three data bits, and then issues a start, nine released clocks and a second start. It checks that the line stays released through those clocks, and then that the counter still points just past the interrupted byte. Acknowledge polling is reached by hitting the engine with its own address right after a write commit, while the bench's page-write model is still busy.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RDATA
  } sm_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sync;
  logic [SYNC_STAGES-1:0] sda_sync;
  logic scl_q, sda_q, scl_lvl;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= scl_in;
          sda_sync <= sda_in;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
          sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  assign scl_lvl = scl_sync[SYNC_STAGES-1];
  assign sda_lvl = sda_sync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_lvl;
      sda_q <= sda_lvl;
    end
  end

  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/addr_counter.sv
module addr_counter #(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_array,
  input  logic              step_page,
  output logic [ADDR_W-1:0] cnt
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (step_array)
      cnt <= cnt + 1'b1;
    else if (step_page)
      cnt <= {cnt[ADDR_W-1:PAGE_W], cnt[PAGE_W-1:0] + 1'b1};
  end

  AST_PAGE_ROW_KEPT: assert property (@(posedge clk) disable iff (rst)
    (step_page && !load && !step_array) |=> cnt[ADDR_W-1:PAGE_W] == $past(cnt[ADDR_W-1:PAGE_W])); // R5

  AST_ARRAY_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step_array && !load && cnt == {ADDR_W{1'b1}}) |=> cnt == '0); // R8

  initial begin
    AST_ROW_WIDTH: assert (ROW_W > 0); // R5
  end
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter int ADDR_W      = 14,
  parameter int PAGE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        strap_sel,
  output logic              sda_oe,
  input  logic              wr_busy,
  output logic              wr_push,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  import sm_pkg::*;

  localparam int HI_W = ADDR_W - 8;

  sm_state_e         st;
  logic [3:0]        bit_cnt;
  logic [7:0]        shreg;
  logic [7:0]        txreg;
  logic [HI_W-1:0]   addr_hi;
  logic              ack_ok;
  logic              wrote;
  logic              load_q;

  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic dev_match, ack_clk_rise, fetch_evt;
  logic ctr_load, ctr_step_page;
  logic [ADDR_W-1:0] ctr;

  bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign dev_match    = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == strap_sel);
  assign ack_clk_rise = scl_rise && (bit_cnt == 4'd8);
  assign fetch_evt    = ack_clk_rise &&
                        (((st == ST_DEV) && ack_ok && shreg[0]) ||
                         ((st == ST_RDATA) && !sda_lvl));
  assign ctr_load      = ack_clk_rise && (st == ST_ALO);
  assign ctr_step_page = scl_rise && (st == ST_WDATA) && (bit_cnt == 4'd7);

  addr_counter #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk(clk), .rst(rst),
    .load(ctr_load), .load_val({addr_hi, shreg}),
    .step_array(fetch_evt), .step_page(ctr_step_page),
    .cnt(ctr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      txreg     <= '0;
      addr_hi   <= '0;
      ack_ok    <= 1'b0;
      wrote     <= 1'b0;
      load_q    <= 1'b0;
      sda_oe    <= 1'b0;
      wr_push   <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
    end else begin
      wr_push   <= 1'b0;
      wr_commit <= 1'b0;
      rd_en     <= 1'b0;
      load_q    <= rd_en;
      if (load_q)
        txreg <= rd_data;

      if (start_det) begin
        st      <= ST_DEV;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
        wrote   <= 1'b0;
        ack_ok  <= 1'b0;
      end else if (stop_det) begin
        st        <= ST_IDLE;
        sda_oe    <= 1'b0;
        wr_commit <= (st == ST_WDATA) && wrote;
        wrote     <= 1'b0;
      end else if (scl_rise && st != ST_IDLE) begin
        if (bit_cnt != 4'd8) begin
          shreg   <= {shreg[6:0], sda_lvl};
          bit_cnt <= bit_cnt + 1'b1;
          if (ctr_step_page) begin
            wr_push <= 1'b1;
            wr_addr <= ctr;
            wr_data <= {shreg[6:0], sda_lvl};
            wrote   <= 1'b1;
          end
        end else begin
          bit_cnt <= '0;
          if (fetch_evt) begin
            rd_en   <= 1'b1;
            rd_addr <= ctr;
          end
          unique case (st)
            ST_DEV:   st <= !ack_ok ? ST_IDLE : (shreg[0] ? ST_RDATA : ST_AHI);
            ST_AHI: begin
              addr_hi <= shreg[HI_W-1:0];
              st      <= ST_ALO;
            end
            ST_ALO:   st <= ST_WDATA;
            ST_WDATA: st <= ST_WDATA;
            ST_RDATA: st <= sda_lvl ? ST_IDLE : ST_RDATA;
            default:  st <= ST_IDLE;
          endcase
        end
      end else if (scl_fall && st != ST_IDLE) begin
        if (bit_cnt == 4'd8) begin
          unique case (st)
            ST_DEV: begin
              ack_ok <= dev_match && !wr_busy;
              sda_oe <= dev_match && !wr_busy;
            end
            ST_RDATA: sda_oe <= 1'b0;
            default:  sda_oe <= 1'b1;
          endcase
        end else if (st == ST_RDATA && !load_q) begin
          sda_oe <= !txreg[7];
          txreg  <= {txreg[6:0], 1'b0};
        end else begin
          sda_oe <= 1'b0;
        end
      end
    end
  end

  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det)); // R12

  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (scl_fall && st == ST_DEV && bit_cnt == 4'd8 && wr_busy) |=> !sda_oe); // R3

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe); // R10

  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> !wr_commit); // R6

  AST_PUSH_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_push |-> $past(st == ST_WDATA)); // R5

  AST_START_TO_DEV: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (st == ST_DEV && !sda_oe)); // R1
endmodule

// File: tb/serial_mem_slave_test.sv
module serial_mem_slave_test;
  localparam int AW    = 14;
  localparam int Q     = 10;
  localparam int BUSY  = 3000;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe, wr_push, wr_commit, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data = 8'h00;
  logic wr_busy;

  int checks = 0, errs = 0, mon_checks = 0, mon_errs = 0;
  int busy_cnt = 0, commits = 0;
  logic [7:0] mem_q [int];
  logic [21:0] sb [$];

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign wr_busy  = (busy_cnt != 0);

  serial_mem_slave uut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
    .strap_sel(STRAP), .sda_oe(sda_oe), .wr_busy(wr_busy),
    .wr_push(wr_push), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  function automatic logic [7:0] pat(int a);
    logic [13:0] x;
    x = a[13:0];
    return x[7:0] ^ {2'b00, x[13:8]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] mem_val(int a);
    int k;
    k = a & 16'h3FFF;
    if (mem_q.exists(k)) return mem_q[k];
    return pat(k);
  endfunction

  // memory model, page-write model and scoreboard monitor
  always @(posedge clk) begin
    if (rd_en) rd_data <= mem_val(int'(rd_addr));
    if (wr_push) begin
      mon_checks++;
      if (sb.size() == 0) begin
        mon_errs++;
        $display("FAIL R5 unexpected push actual %0h/%0h expected none", wr_addr, wr_data);
      end else begin
        logic [21:0] e;
        e = sb.pop_front();
        if (e != {wr_addr, wr_data}) begin
          mon_errs++;
          $display("FAIL R5 push actual %0h expected %0h", {wr_addr, wr_data}, e);
        end
      end
      mem_q[int'(wr_addr)] = wr_data;
    end
    if (wr_commit) begin
      commits++;
      busy_cnt = BUSY;
    end else if (busy_cnt > 0) begin
      busy_cnt--;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errs + mon_errs);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b0; hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b1; hold();
  endtask

  task automatic clk_bit(input logic b, output logic s1, output logic s2);
    sda_m = b; hold();
    scl_m = 1'b1; hold();
    s1 = sda_line; hold();
    s2 = sda_line;
    scl_m = 1'b0; hold();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s1, s2);
    clk_bit(1'b1, s1, s2);
    acked = !s1;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d, output logic stab);
    logic s1, s2;
    stab = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s1, s2);
      d = {d[6:0], s1};
      if (s1 != s2) stab = 1'b0;
    end
    clk_bit(!mack, s1, s2);
  endtask

  task automatic read_bytes(input int first, input int n, input string tag);
    logic [7:0] d;
    logic stab;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d, stab);
      check(d == mem_val(first + k), tag, d, mem_val(first + k));
      check(stab, "R12 read bit stable while clock high", stab, 1);
    end
    i2c_stop();
  endtask

  task automatic cur_read(input int first, input int n, input string tag);
    logic a;
    i2c_start();
    send_byte(DEV_R, a);
    check(a, "R2 read address ack", a, 1);
    read_bytes(first, n, tag);
  endtask

  task automatic set_addr(input logic [15:0] addr);
    logic a;
    i2c_start();
    send_byte(DEV_W, a);
    check(a, "R2 write address ack", a, 1);
    send_byte(addr[15:8], a);
    check(a, "R4 word address high ack", a, 1);
    send_byte(addr[7:0], a);
    check(a, "R4 word address low ack", a, 1);
  endtask

  task automatic rand_read(input logic [15:0] addr, input int n, input string tag);
    set_addr(addr);
    cur_read(int'(addr[13:0]), n, tag);
  endtask

  initial begin
    logic a, s1, s2;
    int c0;
    logic [13:0] base;
    logic [7:0] wd [3];
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!sda_oe && !wr_push && !wr_commit && !rd_en, "R1 reset outputs idle",
          {sda_oe, wr_push, wr_commit, rd_en}, 0);

    // R9: counter starts at zero, then advances
    cur_read(0, 1, "R9 current read after reset");
    cur_read(1, 1, "R9 current read follows counter");

    // R2: strap and code mismatch
    i2c_start(); send_byte({4'b1010, 3'b011, 1'b0}, a); i2c_stop();
    check(!a, "R2 strap mismatch no ack", a, 0);
    i2c_start(); send_byte({4'b1011, STRAP, 1'b0}, a); i2c_stop();
    check(!a, "R2 code mismatch no ack", a, 0);

    // R4 and R7: top address bits ignored, random read
    c0 = commits;
    rand_read(16'hC123, 2, "R7 random read with ignored A15:A14 (R4)");
    // R8: sequential wrap at the array end
    rand_read(16'h3FFE, 3, "R8 sequential read wraps to zero");
    cur_read(1, 1, "R9 counter after wrap");
    check(commits == c0, "R6 no commit for address-only write", commits, c0);

    // R5: page write with wrap inside the page
    base = 14'h013E;
    wd[0] = 8'hA1; wd[1] = 8'hB2; wd[2] = 8'hC3;
    set_addr({2'b00, base});
    for (int k = 0; k < 3; k++) begin
      logic [13:0] ea;
      ea = {base[13:6], base[5:0] + 6'(k)};
      sb.push_back({ea, wd[k]});
      send_byte(wd[k], a);
      check(a, "R5 data byte ack", a, 1);
    end
    i2c_stop();
    repeat (4) @(negedge clk);
    check(commits == c0 + 1, "R6 one commit after stop", commits, c0 + 1);
    check(sb.size() == 0, "R5 all pushes seen", sb.size(), 0);

    // R3: acknowledge polling
    i2c_start(); send_byte(DEV_W, a); i2c_stop();
    check(!a, "R3 no ack while busy", a, 0);
    a = 1'b0;
    for (int t = 0; t < 40; t++) begin
      i2c_start(); send_byte(DEV_W, a); i2c_stop();
      if (a) break;
    end
    check(a && !wr_busy, "R3 ack once write done", a, 1);

    cur_read(14'h0101, 1, "R5 counter after page wrap");
    rand_read(16'h013E, 2, "R5 written bytes read back");
    rand_read(16'h0100, 1, "R5 wrapped byte read back");
    check(mem_val(14'h0100) == 8'hC3, "R5 wrapped byte value", mem_val(14'h0100), 8'hC3);

    // R1: repeated start aborts a write after the high address byte
    i2c_start(); send_byte(DEV_W, a); send_byte(8'h02, a);
    cur_read(14'h0101, 1, "R1 start abort keeps counter");

    // R11: software reset in the middle of a read byte
    i2c_start(); send_byte(DEV_R, a);
    for (int i = 0; i < 3; i++) clk_bit(1'b1, s1, s2);
    i2c_start();
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, s1, s2);
      if (i >= 1) check(s1 && s2, "R11 line released in dummy clocks", {s1, s2}, 3);
    end
    i2c_start();
    i2c_stop();
    cur_read(14'h0103, 1, "R11 normal read after software reset");

    // R10: nothing driven after master no-acknowledge
    i2c_start(); send_byte(DEV_R, a);
    begin
      logic [7:0] d; logic st;
      recv_byte(1'b0, d, st);
      check(d == mem_val(14'h0104), "R10 byte before nack", d, mem_val(14'h0104));
    end
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, s1, s2);
      check(s1 && s2 && !sda_oe, "R10 released after nack", {s1, s2}, 3);
    end
    i2c_stop();
    check(!sda_oe, "R1 released after stop", sda_oe, 0);

    $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errs + mon_errs);
    $finish;
  end
endmodule